// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that keeps a small bank of 8-bit control registers for a clock-generator control plane. SCL and SDA arrive already synchronised to a fast system clock. The block answers by pulling SDA low through an open-drain enable output. Every register is also presented in parallel on one flat output bus, so the rest of the control plane can use the settings directly.

Writes never carry a register address. After the write address byte, the master sends two bytes that the slave acknowledges and throws away. The bytes after those fill register 0, register 1 and so on, until a STOP arrives. A read first returns a count of the implemented registers, then the registers themselves in ascending order, until the master answers with NACK. START and STOP are found by looking at SDA edges while SCL is high. The interface runs at the standard 100 kbit/s rate, and the system clock is many times faster.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The address byte 0xD2 (device address 0x69, write) and the address byte 0xD3 (device address 0x69, read) are both acknowledged: the slave drives SDA low during the ninth SCL pulse.
- R2: On a write, the slave acknowledges the first two bytes after the address and discards their values. Neither byte changes any register.
- R3: Each later byte of a write is acknowledged and stored in ascending register order, starting at register 0. Data bits arrive MSB first.
- R4: A write may end after any complete byte. Registers that were written keep their new values, and the other registers keep their old ones.
- R5: Data bytes beyond the last register (index 5) are acknowledged and discarded.
- R6: Reset sets register 0 to 0x00 and registers 1 to 5 to 0xFF, and leaves SDA released. Register k appears on cfg_o[8k+7:8k].
- R7: A read returns the value 6 first, then register 0, 1, 2 and so on, each byte MSB first.
- R8: A read past register 5 returns 0xFF. After the master sends NACK, the slave releases SDA and stays quiet until the next START.
- R9: An address byte that does not match is not acknowledged. The bytes that follow it, up to the next START, get no acknowledge and change no register.
- R10: A repeated START begins address matching again, so a read may follow a write without a STOP between them. A STOP always releases SDA.
- R11: sda_oe changes only while SCL is low. It never changes while SCL stays high and SDA is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock, already synchronised to clk |
| sda_i | input | 1 | Serial data line as seen on the wire, already synchronised |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_o | output | 48 | Flat register bank, register k in bits [8k+7:8k] |

## Verification
The bench goes after the two discarded leading bytes. If a design stored them, registers 0 and 1 would hold the command and count values. It also tests writes that stop part-way and writes that run past register 5. A design that got these wrong would clear unwritten registers or wrap around and overwrite register 0. For reads, the bench checks that the count byte comes first and that 0xFF is returned past the end. An off-by-one pointer would show register 1 in place of register 0.

The bench also covers near-miss addresses, a repeated START after a write, and a reset in the middle of a transfer. A design that got these wrong would acknowledge traffic meant for another device, stay stuck in write mode, or keep data from before the reset. A monitor also watches for the enable changing while SCL is high, which a design reacting to the wrong SCL edge would do.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_MACK
  } st_e;

  localparam logic [7:0] PAST_END_BYTE = 8'hFF;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // SDA edges while SCL is held high mark bus conditions
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NUM_REGS = 6,
  parameter int PTR_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = (g == 0) ? 8'h00 : 8'hFF;
    logic [7:0] val_q;
    logic       ld;

    assign ld = wr_en && (wr_idx == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= RST_VAL;
      else if (ld) val_q <= wr_data;
    end

    assign cfg_o[g*8 +: 8] = val_q;
  end
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter int         PTR_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sda_i,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_det,
  input  logic                  stop_det,
  input  logic [NUM_REGS*8-1:0] cfg_i,
  output logic                  sda_oe,
  output logic                  wr_en,
  output logic [PTR_W-1:0]      wr_idx,
  output logic [7:0]            wr_data
);
  localparam logic [PTR_W-1:0] DUMMY_N = PTR_W'(2);
  localparam logic [PTR_W-1:0] WR_SAT  = PTR_W'(NUM_REGS + 2);
  localparam logic [PTR_W-1:0] RD_SAT  = PTR_W'(NUM_REGS);

  st_e              state_q, state_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       shift_q, shift_d;
  logic             rw_q, rw_d;
  logic             nack_q, nack_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [7:0]       rd_byte;

  always_comb begin
    rd_byte = PAST_END_BYTE;
    for (int k = 0; k < NUM_REGS; k++)
      if (ptr_q == PTR_W'(k)) rd_byte = cfg_i[k*8 +: 8];
  end

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    ptr_d   = ptr_q;
    wr_en   = 1'b0;
    wr_idx  = ptr_q - DUMMY_N;
    wr_data = shift_q;
    if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = 4'd0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && bit_q != 4'd8) begin
            shift_d = {shift_q[6:0], sda_i};
            bit_d   = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d = 4'd0;
            if (state_q == ST_ADDR) begin
              if (shift_q[7:1] == DEV_ADDR) begin
                state_d = ST_ACK_A;
                rw_d    = shift_q[0];
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              state_d = ST_ACK_RX;
              wr_en   = (ptr_q >= DUMMY_N) && (ptr_q < WR_SAT);
              if (ptr_q != WR_SAT) ptr_d = ptr_q + PTR_W'(1);
            end
          end
        end
        ST_ACK_A: if (scl_fall) begin
          ptr_d = '0;
          bit_d = 4'd0;
          if (rw_q) begin
            state_d = ST_TX;
            shift_d = 8'(NUM_REGS);
          end else begin
            state_d = ST_RX;
          end
        end
        ST_ACK_RX: if (scl_fall) state_d = ST_RX;
        ST_TX: if (scl_fall) begin
          if (bit_q == 4'd7) begin
            state_d = ST_MACK;
            bit_d   = 4'd0;
          end else begin
            shift_d = {shift_q[6:0], 1'b0};
            bit_d   = bit_q + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_d = sda_i;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_TX;
              shift_d = rd_byte;
              if (ptr_q != RD_SAT) ptr_d = ptr_q + PTR_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= 4'd0;
      shift_q <= 8'h00;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      ptr_q   <= ptr_d;
    end
  end

  assign sda_oe = (state_q == ST_ACK_A) || (state_q == ST_ACK_RX) ||
                  ((state_q == ST_TX) && !shift_q[7]);
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int PTR_W = $clog2(NUM_REGS + 3);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_line_events u_evt (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_proto_fsm #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .cfg_i(cfg_o), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NUM_REGS = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_i,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg_o,
  input logic                  st_idle
);
  // R11: the enable stays put while SCL was high and SDA steady
  a_r11_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && $past(scl_i, 2) && ($past(sda_i) == $past(sda_i, 2)))
      |-> $stable(sda_oe));

  // R10: a STOP condition on the wire leaves SDA released
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && $past(scl_i, 2) && $past(sda_i) && !$past(sda_i, 2))
      |-> !sda_oe);

  // R3: a register update coincides with the slave's acknowledge
  a_r3_update_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> sda_oe);

  // R9: an idle slave changes no register
  a_r9_idle_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> $stable(cfg_o));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .cfg_o(cfg_o),
  .st_idle(u_fsm.state_q == cfg_i2c_pkg::ST_IDLE)
);

// File: tb/sim_cfg_i2c_slave.sv
`timescale 1ns/1ps
module sim_cfg_i2c_slave;
  localparam int Q = 10;
  localparam logic [47:0] RST_CFG = 48'hFFFF_FFFF_FF00;
  // fields: [99:96] data byte count, [95:48] data bytes (byte k at 8k), [47:0] expected bank
  localparam logic [99:0] VEC [4] = '{
    {4'd6, 48'h665544332211, 48'h665544332211},
    {4'd2, 48'h000000005AA5, 48'h665544335AA5},
    {4'd0, 48'h000000000000, 48'h665544335AA5},
    {4'd8, 48'h060504030201, 48'h060504030201}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, scl_m, m_low;
  logic        sda_oe;
  logic [47:0] cfg;
  wire         sda_line = !(m_low || sda_oe);

  cfg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg)
  );

  int checks = 0, errors = 0, viol = 0;
  bit done = 1'b0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_oe = 1'b0;

  // R11 monitor: enable must not move while SCL high and SDA steady
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_line == prev_sda) && (sda_oe != prev_oe) && !m_low)
      viol++;
    prev_scl = scl_m; prev_sda = sda_line; prev_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    m_low = 1'b0; qw(); scl_m = 1'b1; qw(); m_low = 1'b1; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; qw(); scl_m = 1'b1; qw(); m_low = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
    m_low = 1'b0; qw(); scl_m = 1'b1; qw(); ack = !sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rbyte(output logic [7:0] b, input bit nack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0; qw();
    end
    m_low = !nack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); m_low = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] n, input logic [47:0] d, output bit all_ack);
    bit a;
    all_ack = 1'b1;
    i2c_start();
    wbyte(8'hD2, a); all_ack &= a;
    wbyte(8'h5C, a); all_ack &= a;
    wbyte(8'h3A, a); all_ack &= a;
    for (int k = 0; k < int'(n); k++) begin
      wbyte((k < 6) ? d[k*8 +: 8] : 8'hEE, a);
      all_ack &= a;
    end
    i2c_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    rst_n = 1'b0; scl_m = 1'b1; m_low = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 reset bank", 64'(cfg), 64'(RST_CFG));
    chk("R6 reset sda", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < 4; v++) begin
      do_write(VEC[v][99:96], VEC[v][95:48], a);
      chk("R1 R2 R3 R5 acks", 64'(a), 64'd1);
      chk("R2 R3 R4 R5 bank", 64'(cfg), 64'(VEC[v][47:0]));
    end

    // read-back: R1 R7 R8
    i2c_start();
    wbyte(8'hD3, a); chk("R1 read addr ack", 64'(a), 64'd1);
    rbyte(b, 1'b0);  chk("R7 count byte", 64'(b), 64'd6);
    for (int k = 0; k < 6; k++) begin
      rbyte(b, 1'b0); chk("R7 register", 64'(b), 64'(k + 1));
    end
    rbyte(b, 1'b0); chk("R8 past end", 64'(b), 64'hFF);
    rbyte(b, 1'b1); chk("R8 past end again", 64'(b), 64'hFF);
    qw(); chk("R8 released after nack", 64'(sda_oe), 64'd0);
    i2c_stop();

    // mismatched addresses: R9
    i2c_start();
    wbyte(8'hA4, a); chk("R9 foreign addr", 64'(a), 64'd0);
    wbyte(8'h00, a); chk("R9 ignored byte", 64'(a), 64'd0);
    wbyte(8'h00, a); chk("R9 ignored byte 2", 64'(a), 64'd0);
    i2c_stop();
    i2c_start();
    wbyte(8'hD0, a); chk("R9 near miss addr", 64'(a), 64'd0);
    i2c_stop();
    chk("R9 bank untouched", 64'(cfg), 64'h060504030201);

    // repeated start: R10
    i2c_start();
    wbyte(8'hD2, a); wbyte(8'h01, a); wbyte(8'h02, a);
    wbyte(8'h77, a); chk("R10 data ack", 64'(a), 64'd1);
    i2c_start();
    wbyte(8'hD3, a); chk("R10 read after restart", 64'(a), 64'd1);
    rbyte(b, 1'b0);  chk("R10 count", 64'(b), 64'd6);
    rbyte(b, 1'b1);  chk("R10 reg0", 64'(b), 64'h77);
    i2c_stop();
    chk("R10 stop released", 64'(sda_oe), 64'd0);
    chk("R4 partial keeps rest", 64'(cfg), 64'h060504030277);

    // reset in mid-transfer: R6
    i2c_start();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h12, a);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 mid-transfer reset", 64'(cfg), 64'(RST_CFG));
    chk("R6 sda released", 64'(sda_oe), 64'd0);
    rst_n = 1'b1; m_low = 1'b0;
    repeat (4) @(negedge clk);
    i2c_stop();

    // write after a reset works again: R3
    do_write(4'd1, 48'h0000000000C3, a);
    chk("R3 post-reset write", 64'(cfg), 64'hFFFF_FFFF_FFC3);

    chk("R11 enable stable while SCL high", 64'(viol), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule